// File: doc/BRIEF.md
# System Management Event Aggregator

This block gathers several system-management event sources into a status word, qualifies each source with its own enable bit and a master enable, and drives an active-low system management interrupt line toward the processor. Two sources are found by watching the I/O write stream: any write to the command port, and a write to the power-management control port that sets its sleep-enable bit. The other three arrive as single-cycle pulses: a firmware-release event, a watchdog event and a periodic tick.

Software owns two 32-bit words on a simple register bus: an enable word at offset 0x30 and a status word at offset 0x34. Status bits are cleared by writing 1 to them. Once the interrupt line is driven low, it stays low until the handler writes the acknowledge bit of the enable word. That write releases the line and re-arms the block, so a source still pending raises the line again on the following cycle. Writing 1 to bit 7 of the enable word sends a one-cycle notify request to the operating-system event path and raises no interrupt.

Top module: `smev_ctrl`

## Requirements
- R1: After reset `smi_n` is 1 and `os_req` is 0. The enable word reads 0x0000_0002 (only the armed flag in bit 1 is set). The status word reads 0.
- R2: No interrupt is raised while enable bit 0 (master) is 0. If a status bit is pending and its source is enabled, writing master = 1 drives `smi_n` low on the cycle after the write.
- R3: Once `smi_n` is low it stays low until the enable word is written with bit 1 (acknowledge) set. A write to the enable word without that bit does not release it.
- R4: Writing acknowledge releases `smi_n` on the edge that takes the write. If an enabled status bit is still set, `smi_n` goes low again one cycle later. If none is set, it stays high.
- R5: With enable bit 5 set, any write to I/O port 0x00B2 sets status bit 5 on the next edge, and `smi_n` falls one edge after that. A write to any other port does not set the bit.
- R6: With enable bit 5 clear, a write to port 0x00B2 leaves status bit 5 at 0 and raises no interrupt.
- R7: With enable bit 4 set, a write to I/O port 0x0404 whose data bit 13 is 1 sets status bit 4. A write there with data bit 13 = 0 sets nothing.
- R8: With enable bit 2 set, a pulse on `rls_evt` sets status bit 2.
- R9: A pulse on `wdog_evt` sets status bit 13 when enable bit 13 is set. A pulse on `per_evt` sets status bit 14 when enable bit 14 is set. A source with its enable bit clear sets no status.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A source event in the same cycle as the clear wins, and the bit stays set.
- R11: Writing 1 to enable bit 7 raises `os_req` for exactly the next cycle. The bit is not stored (it reads 0), and the write raises no interrupt.
- R12: The enable word stores only bits 0, 2, 4, 5, 13 and 14, and reads bit 1 as the armed flag. Unimplemented bits and all other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| io_wr | input | 1 | Snooped I/O write strobe |
| io_addr | input | IO_AW | Snooped I/O port address |
| io_wdata | input | 32 | Snooped I/O write data |
| rls_evt | input | 1 | Firmware-release event pulse |
| wdog_evt | input | 1 | Watchdog event pulse |
| per_evt | input | 1 | Periodic event pulse |
| smi_n | output | 1 | Active-low system management interrupt |
| os_req | output | 1 | One-cycle notify request to the OS event path |

## Verification
A source event or snooped write taken at edge k appears in the status word after edge k, and `smi_n` falls after edge k+1. A register write taken at edge k updates the enable word, the status word, `os_req` and any release of `smi_n` after that same edge, and a re-fire follows one edge later. The bench drives every input just after a falling edge and samples at falling edges, so each check lands in the exact cycle listed above. It also checks that `smi_n` is still high one cycle early, which catches an extra or a missing pipeline stage.

// File: rtl/smev_pkg.sv
package smev_pkg;
  localparam int WORD_W = 32;
  localparam int NSRC   = 5;

  // control bit positions in the enable word
  localparam int MASTER_POS = 0;
  localparam int ACK_POS    = 1;
  localparam int NOTIFY_POS = 7;

  // source indices
  localparam int SRC_RLS  = 0;
  localparam int SRC_SLP  = 1;
  localparam int SRC_CMD  = 2;
  localparam int SRC_WDOG = 3;
  localparam int SRC_PER  = 4;

  // bit shared by a source's enable and status
  function automatic int src_pos(input int idx);
    case (idx)
      SRC_RLS:  return 2;
      SRC_SLP:  return 4;
      SRC_CMD:  return 5;
      SRC_WDOG: return 13;
      default:  return 14;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] src_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[src_pos(i)] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] stored_en_mask();
    return src_mask() | (WORD_W'(1) << MASTER_POS);
  endfunction

  function automatic logic any_pending(input logic [WORD_W-1:0] sts,
                                       input logic [WORD_W-1:0] en);
    return |(sts & en & src_mask());
  endfunction
endpackage

// File: rtl/smev_snoop.sv
module smev_snoop
  import smev_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] CMD_PORT = 16'h00B2,
  parameter logic [IO_AW-1:0] PM_CTL_PORT = 16'h0404,
  parameter int SLP_BIT = 13
) (
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [WORD_W-1:0] io_wdata,
  input  logic              rls_evt,
  input  logic              wdog_evt,
  input  logic              per_evt,
  output logic [NSRC-1:0]   raw_evt
);
  logic unused_wdata;
  assign unused_wdata = ^io_wdata;

  always_comb begin
    raw_evt           = '0;
    raw_evt[SRC_RLS]  = rls_evt;
    raw_evt[SRC_SLP]  = io_wr && (io_addr == PM_CTL_PORT) && io_wdata[SLP_BIT];
    raw_evt[SRC_CMD]  = io_wr && (io_addr == CMD_PORT);
    raw_evt[SRC_WDOG] = wdog_evt;
    raw_evt[SRC_PER]  = per_evt;
  end
endmodule

// File: rtl/smev_enreg.sv
module smev_enreg
  import smev_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EN_OFF = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              fire,
  output logic [WORD_W-1:0] en_q,
  output logic              arm_q,
  output logic              ack_wr,
  output logic              os_req
);
  logic en_hit;
  assign en_hit = reg_wr && (reg_addr == EN_OFF);
  assign ack_wr = en_hit && reg_wdata[ACK_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      arm_q  <= 1'b1;
      os_req <= 1'b0;
    end else begin
      if (en_hit) en_q <= reg_wdata & stored_en_mask();
      os_req <= en_hit && reg_wdata[NOTIFY_POS];
      if (fire)        arm_q <= 1'b0;
      else if (ack_wr) arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/smev_status.sv
module smev_status
  import smev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   raw_evt,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NSRC-1:0]   clr_vec,
  output logic [NSRC-1:0]   set_vec,
  output logic [WORD_W-1:0] sts_q
);
  logic [NSRC-1:0] bit_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign set_vec[g] = raw_evt[g] && src_en[g];
    always_ff @(posedge clk) begin
      if (!rst_n)          bit_q[g] <= 1'b0;
      else if (set_vec[g]) bit_q[g] <= 1'b1;
      else if (clr_vec[g]) bit_q[g] <= 1'b0;
    end
  end

  always_comb begin
    sts_q = '0;
    for (int i = 0; i < NSRC; i++) sts_q[src_pos(i)] = bit_q[i];
  end
endmodule

// File: rtl/smev_ctrl.sv
module smev_ctrl
  import smev_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IO_AW = 16,
  parameter logic [ADDR_W-1:0] EN_OFF = 8'h30,
  parameter logic [ADDR_W-1:0] STS_OFF = 8'h34,
  parameter logic [IO_AW-1:0] CMD_PORT = 16'h00B2,
  parameter logic [IO_AW-1:0] PM_CTL_PORT = 16'h0404,
  parameter int SLP_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [WORD_W-1:0] io_wdata,
  input  logic              rls_evt,
  input  logic              wdog_evt,
  input  logic              per_evt,
  output logic              smi_n,
  output logic              os_req
);
  logic [NSRC-1:0]   raw_evt, src_en, clr_vec, set_vec;
  logic [WORD_W-1:0] en_q, sts_q;
  logic              arm_q, ack_wr, pending, fire, smi_act, sts_hit;

  smev_snoop #(
    .IO_AW(IO_AW), .CMD_PORT(CMD_PORT), .PM_CTL_PORT(PM_CTL_PORT), .SLP_BIT(SLP_BIT)
  ) u_snoop (
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .rls_evt(rls_evt), .wdog_evt(wdog_evt), .per_evt(per_evt),
    .raw_evt(raw_evt)
  );

  smev_enreg #(.ADDR_W(ADDR_W), .EN_OFF(EN_OFF)) u_enreg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fire(fire), .en_q(en_q), .arm_q(arm_q),
    .ack_wr(ack_wr), .os_req(os_req)
  );

  assign sts_hit = reg_wr && (reg_addr == STS_OFF);

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      src_en[i]  = en_q[src_pos(i)];
      clr_vec[i] = sts_hit && reg_wdata[src_pos(i)];
    end
  end

  smev_status u_status (
    .clk(clk), .rst_n(rst_n), .raw_evt(raw_evt), .src_en(src_en),
    .clr_vec(clr_vec), .set_vec(set_vec), .sts_q(sts_q)
  );

  // interrupt line: fires once per arm, held until acknowledged
  assign pending = any_pending(sts_q, en_q);
  assign fire    = en_q[MASTER_POS] && arm_q && pending;

  always_ff @(posedge clk) begin
    if (!rst_n)      smi_act <= 1'b0;
    else if (fire)   smi_act <= 1'b1;
    else if (ack_wr) smi_act <= 1'b0;
  end
  assign smi_n = ~smi_act;

  always_comb begin
    if (reg_addr == EN_OFF)       reg_rdata = en_q | (WORD_W'(arm_q) << ACK_POS);
    else if (reg_addr == STS_OFF) reg_rdata = sts_q;
    else                          reg_rdata = '0;
  end
endmodule

// File: rtl/smev_chk.sv
module smev_chk
  import smev_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IO_AW = 16,
  parameter logic [ADDR_W-1:0] EN_OFF = 8'h30,
  parameter logic [ADDR_W-1:0] STS_OFF = 8'h34,
  parameter logic [IO_AW-1:0] CMD_PORT = 16'h00B2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smi_n,
  input logic              os_req,
  input logic [WORD_W-1:0] en_q,
  input logic [WORD_W-1:0] sts_q,
  input logic              arm_q,
  input logic              smi_act,
  input logic              ack_wr,
  input logic              pending,
  input logic [NSRC-1:0]   set_vec,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              io_wr,
  input logic [IO_AW-1:0]  io_addr
);
  localparam int CMD_BIT = src_pos(SRC_CMD);

  // R2
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smi_n) |-> $past(en_q[MASTER_POS]));

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smi_n && !ack_wr) |=> !smi_n);

  // R3
  arm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_q && smi_act));

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smi_n && ack_wr) |=> smi_n);

  // R4
  refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_wr) && smi_n && en_q[MASTER_POS] && pending) |=> !smi_n);

  // R5
  cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == CMD_PORT && en_q[CMD_BIT]) |=> sts_q[CMD_BIT]);

  // R6
  cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == CMD_PORT && !en_q[CMD_BIT] && !sts_q[CMD_BIT]) |=> !sts_q[CMD_BIT]);

  // R10
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STS_OFF && set_vec == '0) |=> ((sts_q & $past(reg_wdata)) == '0));

  // R11
  notify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == EN_OFF && reg_wdata[NOTIFY_POS]) |=> os_req);
endmodule

bind smev_ctrl smev_chk #(
  .ADDR_W(ADDR_W), .IO_AW(IO_AW), .EN_OFF(EN_OFF), .STS_OFF(STS_OFF), .CMD_PORT(CMD_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smi_n(smi_n), .os_req(os_req), .en_q(en_q),
  .sts_q(sts_q), .arm_q(arm_q), .smi_act(smi_act), .ack_wr(ack_wr),
  .pending(pending), .set_vec(set_vec), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .io_wr(io_wr), .io_addr(io_addr)
);

// File: tb/smev_ctrl_bench.sv
`timescale 1ns/1ps
module smev_ctrl_bench;
  localparam logic [7:0]  EN  = 8'h30;
  localparam logic [7:0]  STS = 8'h34;
  localparam logic [15:0] CMD = 16'h00B2;
  localparam logic [15:0] PMC = 16'h0404;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, reg_wr, io_wr, rls_evt, wdog_evt, per_evt, smi_n, os_req;
  logic [7:0]  reg_addr;
  logic [15:0] io_addr;
  logic [31:0] reg_wdata, reg_rdata, io_wdata, rd;
  int n_cmp = 0;
  int n_bad = 0;

  smev_ctrl u_smev_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .rls_evt(rls_evt),
    .wdog_evt(wdog_evt), .per_evt(per_evt), .smi_n(smi_n), .os_req(os_req)
  );

  function automatic int bitpos(input int s);
    int t[5] = '{2, 4, 5, 13, 14};
    return t[s];
  endfunction

  function automatic string tag(input int s, input int e);
    case (s)
      0: return "R8";
      1: return "R7";
      2: return (e != 0) ? "R5" : "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [31:0] d);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(posedge clk); @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic trigger(input int s);
    case (s)
      1: io_write(PMC, 32'h1 << 13);
      2: io_write(CMD, 32'h0);
      default: begin
        rls_evt = (s == 0); wdog_evt = (s == 3); per_evt = (s == 4);
        @(posedge clk); @(negedge clk);
        rls_evt = 1'b0; wdog_evt = 1'b0; per_evt = 1'b0;
      end
    endcase
  endtask

  task automatic clean();
    reg_write(EN, 32'h2);
    reg_write(STS, 32'hFFFF_FFFF);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; io_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    io_addr = '0; io_wdata = '0; rls_evt = 1'b0; wdog_evt = 1'b0; per_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 smi_n", 32'(smi_n), 32'd1);
    chk("R1 os_req", 32'(os_req), 32'd0);
    reg_read(EN, rd);  chk("R1 enable word", rd, 32'h2);
    reg_read(STS, rd); chk("R1 status word", rd, 32'h0);

    // sweep: every source x master x source enable
    for (int s = 0; s < 5; s++) begin
      for (int g = 0; g < 2; g++) begin
        for (int e = 0; e < 2; e++) begin
          logic [31:0] enval, sb;
          sb = 32'h1 << bitpos(s);
          enval = 32'(g) | (e != 0 ? sb : 32'h0);
          clean();
          reg_write(EN, enval);
          trigger(s);
          reg_read(STS, rd);
          chk(tag(s, e), rd, (e != 0) ? sb : 32'h0);
          chk("R2 not yet", 32'(smi_n), 32'd1);
          @(negedge clk);
          chk("R2 line", 32'(smi_n), (g != 0 && e != 0) ? 32'd0 : 32'd1);
          if (g != 0 && e != 0) begin
            repeat (3) @(negedge clk);
            chk("R3 held", 32'(smi_n), 32'd0);
            reg_write(EN, enval);
            chk("R3 no ack", 32'(smi_n), 32'd0);
            reg_read(EN, rd);
            chk("R12 disarmed readback", rd, enval);
            reg_write(EN, enval | 32'h2);
            chk("R4 release", 32'(smi_n), 32'd1);
            @(negedge clk);
            chk("R4 refire", 32'(smi_n), 32'd0);
            reg_write(STS, sb);
            reg_read(STS, rd);
            chk("R10 clear", rd, 32'h0);
            reg_write(EN, enval | 32'h2);
            repeat (3) @(negedge clk);
            chk("R4 stays high", 32'(smi_n), 32'd1);
          end
          if (g == 0 && e != 0) begin
            reg_write(EN, enval | 32'h1);
            chk("R2 master late", 32'(smi_n), 32'd1);
            @(negedge clk);
            chk("R2 master on", 32'(smi_n), 32'd0);
          end
        end
      end
    end

    // R7 sleep write without the sleep bit, R5 neighbouring port
    clean();
    reg_write(EN, 32'h1 | (32'h1 << 4) | (32'h1 << 5));
    io_write(PMC, ~(32'h1 << 13));
    io_write(CMD + 16'h1, 32'hFF);
    io_write(PMC + 16'h1, 32'hFFFF_FFFF);
    reg_read(STS, rd); chk("R7 R5 no status", rd, 32'h0);
    @(negedge clk);
    chk("R7 no line", 32'(smi_n), 32'd1);

    // R10 write 0 leaves, set beats clear
    clean();
    reg_write(EN, 32'h1 << 13);
    trigger(3);
    reg_write(STS, ~(32'h1 << 13));
    reg_read(STS, rd); chk("R10 zero keeps", rd, 32'h1 << 13);
    wdog_evt = 1'b1;
    reg_write(STS, 32'h1 << 13);
    wdog_evt = 1'b0;
    reg_read(STS, rd); chk("R10 set wins", rd, 32'h1 << 13);
    reg_write(STS, 32'h1 << 13);
    reg_read(STS, rd); chk("R10 cleared", rd, 32'h0);

    // R11 notify pulse
    clean();
    reg_write(EN, 32'h80 | 32'h21);
    chk("R11 pulse", 32'(os_req), 32'd1);
    @(negedge clk);
    chk("R11 one cycle", 32'(os_req), 32'd0);
    chk("R11 no line", 32'(smi_n), 32'd1);
    reg_read(EN, rd); chk("R11 not stored", rd, 32'h23);

    // R12 layout
    clean();
    reg_write(EN, 32'hFFFF_FFFF);
    reg_read(EN, rd);      chk("R12 mask", rd, 32'h6037);
    reg_read(8'h38, rd);   chk("R12 other offset", rd, 32'h0);
    reg_read(STS, rd);     chk("R12 status empty", rd, 32'h0);
    clean();

    summary();
    $finish;
  end
endmodule